// File: doc/BRIEF.md
# Flash Read Page Buffer Controller

This block sits between a 32-bit system bus and a slow flash array and hides most of the array's access time. It keeps two independent page buffers of 32 bytes each. The read section of the array, chosen by one fixed address bit, decides which buffer is used. Each buffer remembers the page address it holds and whether that content is valid.

A bus read is decoded first. A malformed address gets an error response and nothing else happens. If the requested page is resident in the buffer for its section, the selected bytes are returned in the same clock. Otherwise that buffer is invalidated, a full page is fetched from the array, the buffer is refilled and tagged, and the bytes are returned in the second clock. Control events from the program and erase logic discard both buffers, so stale flash content is never served.

The array port is page-wide. The array samples a request at a clock edge and presents the page during the following clock.

Top module: `flash_rd_page_cache`

## Requirements
- R1: After reset both buffers are invalid, `busRdy`, `busErr` and `arrReq` are low with no request, and the first read of any page is a miss.
- R2: An address is rejected when any of the following holds: bits [31:25] are not zero; bits [24:22] differ from parameter `MAP_SLOT`; the module code in bits [21:18] is above 1; the module code is 1 and the block code in bits [17:15] is 6 or 7. A rejected read completes in one clock with `busRdy`=1, `busErr`=1 and `busData`=0. It makes no array request and leaves both buffers unchanged.
- R3: A read that misses raises `arrReq` in its first clock, with `arrPageAddr` equal to address bits [21:5]. It completes in its second clock with the fetched data and `busErr`=0.
- R4: A read whose page tag (bits [21:5]) matches the valid buffer of its section completes in the request clock with no array request.
- R5: Address bit 14 selects the buffer. A miss replaces only the buffer of its own section, so one page per section stays resident at the same time.
- R6: The word within the page is chosen by bits [4:2], where word 0 is page bits [255:224]. Byte lanes are big-endian, and lanes that are not selected read zero. `busSize` selects the access width: 0 is a byte, 1 is a halfword and 2 or 3 is a word. A byte at offset k appears on bits [31-8k -: 8]. A halfword takes bits [31:16] when address bit 1 is 0 and bits [15:0] when it is 1. A word ignores bits [1:0].
- R7: A one-clock pulse on `progWrStb` or on `eraseIlkStb` invalidates both buffers.
- R8: A rising edge of `hvEnable` and a falling edge of `seqEnable` invalidate both buffers. The opposite edges of these two inputs leave the buffers valid.
- R9: Either edge of `irqEnable` invalidates both buffers.
- R10: An invalidation event that falls in the completion clock of a miss still lets that read return the fetched data, but the refilled buffer is left invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Read request, held until `busRdy` |
| busAddr | input | 32 | Byte address of the read |
| busSize | input | 2 | Access width: 0 byte, 1 halfword, 2 or 3 word |
| busRdy | output | 1 | Read completes in this clock |
| busErr | output | 1 | Read rejected by address decode |
| busData | output | 32 | Read data on the selected lanes, zero elsewhere |
| arrReq | output | 1 | Page fetch request to the array |
| arrPageAddr | output | 17 | Page address of the fetch |
| arrPageData | input | 256 | Page returned by the array one clock after `arrReq` |
| progWrStb | input | 1 | Programming write event |
| eraseIlkStb | input | 1 | Erase interlock write event |
| hvEnable | input | 1 | High-voltage enable control level |
| seqEnable | input | 1 | Program/erase sequence enable control level |
| irqEnable | input | 1 | Interrupt enable control level |

## Verification
The refill of a buffer at the end of a miss and a buffer-wide invalidation can land on the same clock edge. The invalidation must win, while the read in flight still completes with the fetched data. The bench provokes this by pulsing the programming-write event during the second clock of a miss. It then judges the outcome by the data and latency of that read, and by a re-read of the same page, which must take the two-clock miss path again.

// File: rtl/frpc_pkg.sv
package frpc_pkg;
  localparam int ADDR_W      = 32;
  localparam int PAGE_BYTES  = 32;
  localparam int PAGE_WORDS  = PAGE_BYTES / 4;
  localparam int WORD_SEL_W  = $clog2(PAGE_WORDS);
  localparam int PAGE_BITS   = PAGE_BYTES * 8;
  localparam int PAGE_LSB    = $clog2(PAGE_BYTES);
  localparam int TAG_MSB     = 21;
  localparam int TAG_W       = TAG_MSB - PAGE_LSB + 1;
  localparam int SECT_BIT    = 14;
  localparam int NUM_SECT    = 2;
  localparam int BLOCKS_HI   = 6;

  typedef struct packed {
    logic capture;   // latch request, start a fetch
    logic invalSec;  // drop the buffer of the current section
    logic fill;      // write fetched page into the latched section
    logic invalAll;  // drop both buffers
    logic selArr;    // return data from the array port
  } strobe_t;

  typedef enum logic {ST_IDLE, ST_FILL} state_e;
endpackage

// File: rtl/frpc_ctrl.sv
module frpc_ctrl
  import frpc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busReq,
  input  logic    decErr,
  input  logic    hit,
  input  logic    progWrStb,
  input  logic    eraseIlkStb,
  input  logic    hvEnable,
  input  logic    seqEnable,
  input  logic    irqEnable,
  output logic    busRdy,
  output logic    busErr,
  output logic    arrReq,
  output strobe_t strb
);
  state_e state, stateNext;
  logic hvQ, seqQ, irqQ;
  logic ctlEvent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      hvQ   <= 1'b0;
      seqQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      state <= stateNext;
      hvQ   <= hvEnable;
      seqQ  <= seqEnable;
      irqQ  <= irqEnable;
    end
  end

  assign ctlEvent = progWrStb | eraseIlkStb | (hvEnable & ~hvQ)
                  | (~seqEnable & seqQ) | (irqEnable ^ irqQ);

  always_comb begin
    stateNext     = state;
    busRdy        = 1'b0;
    busErr        = 1'b0;
    arrReq        = 1'b0;
    strb          = '0;
    strb.invalAll = ctlEvent;
    case (state)
      ST_IDLE: begin
        if (busReq) begin
          if (decErr) begin
            busRdy = 1'b1;
            busErr = 1'b1;
          end else if (hit) begin
            busRdy = 1'b1;
          end else begin
            arrReq        = 1'b1;
            strb.capture  = 1'b1;
            strb.invalSec = 1'b1;
            stateNext     = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        busRdy      = 1'b1;
        strb.fill   = 1'b1;
        strb.selArr = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R3
  miss_two_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrReq |=> (busRdy && !busErr && !arrReq));
  // R4
  rdy_no_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdy |-> !arrReq);
  // R2
  err_is_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdy && !arrReq));
endmodule

// File: rtl/frpc_dpath.sv
module frpc_dpath
  import frpc_pkg::*;
#(
  parameter logic [2:0] MAP_SLOT = 3'd0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  input  strobe_t              strb,
  input  logic [PAGE_BITS-1:0] arrPageData,
  output logic                 decErr,
  output logic                 hit,
  output logic [31:0]          busData,
  output logic [TAG_W-1:0]     arrPageAddr
);
  logic [TAG_MSB:0]      reqAddrQ;
  logic [1:0]            reqSizeQ;
  logic [NUM_SECT-1:0]   validQ;
  logic [TAG_W-1:0]      tagQ  [NUM_SECT];
  logic [PAGE_BITS-1:0]  dataQ [NUM_SECT];

  logic                  curSec, fillSec;
  logic [TAG_W-1:0]      curTag, fillTag;
  logic [3:0]            modCode;
  logic [2:0]            blkCode;

  assign curSec      = busAddr[SECT_BIT];
  assign curTag      = busAddr[TAG_MSB:PAGE_LSB];
  assign fillSec     = reqAddrQ[SECT_BIT];
  assign fillTag     = reqAddrQ[TAG_MSB:PAGE_LSB];
  assign arrPageAddr = curTag;
  assign modCode     = busAddr[21:18];
  assign blkCode     = busAddr[17:15];

  always_comb begin
    decErr = 1'b0;
    if (busAddr[ADDR_W-1:25] != '0)                 decErr = 1'b1;
    if (busAddr[24:22] != MAP_SLOT)                 decErr = 1'b1;
    if (modCode > 4'd1)                             decErr = 1'b1;
    if (modCode == 4'd1 && int'(blkCode) >= BLOCKS_HI) decErr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ <= '0;
      reqSizeQ <= '0;
    end else if (strb.capture) begin
      reqAddrQ <= busAddr[TAG_MSB:0];
      reqSizeQ <= busSize;
    end
  end

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end else begin
        if (strb.invalAll)
          validQ[i] <= 1'b0;
        else if (strb.fill && (int'(fillSec) == i))
          validQ[i] <= 1'b1;
        else if (strb.invalSec && (int'(curSec) == i))
          validQ[i] <= 1'b0;
        if (strb.fill && (int'(fillSec) == i)) begin
          tagQ[i]  <= fillTag;
          dataQ[i] <= arrPageData;
        end
      end
    end
  end

  assign hit = validQ[curSec] && (tagQ[curSec] == curTag);

  function automatic logic [31:0] pickLanes(logic [31:0] w, logic [1:0] off,
                                            logic [1:0] sz);
    logic [4:0] sh;
    case (sz)
      2'b00: begin
        sh = {~off, 3'b000};
        return w & (32'h0000_00FF << sh);
      end
      2'b01: begin
        sh = {~off[1], 4'b0000};
        return w & (32'h0000_FFFF << sh);
      end
      default: return w;
    endcase
  endfunction

  logic [PAGE_BITS-1:0]  srcPage;
  logic [WORD_SEL_W-1:0] wordSel;
  logic [1:0]            laneOff, laneSz;
  logic [31:0]           srcWord;

  always_comb begin
    srcPage = strb.selArr ? arrPageData      : dataQ[curSec];
    wordSel = strb.selArr ? reqAddrQ[4:2]    : busAddr[4:2];
    laneOff = strb.selArr ? reqAddrQ[1:0]    : busAddr[1:0];
    laneSz  = strb.selArr ? reqSizeQ         : busSize;
    srcWord = srcPage[{~wordSel, 5'b00000} +: 32];
    busData = (strb.selArr || (hit && !decErr)) ? pickLanes(srcWord, laneOff, laneSz)
                                                : 32'h0;
  end

  // R7 R10
  inval_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.invalAll |=> (validQ == '0));
  // R3
  fill_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fill && !strb.invalAll) |=>
      (validQ[reqAddrQ[SECT_BIT]] && tagQ[reqAddrQ[SECT_BIT]] == reqAddrQ[TAG_MSB:PAGE_LSB]));
  // R2
  keep_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.fill && !strb.invalAll) |=> $stable(validQ));
  // R5
  one_sect_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.invalSec && !strb.invalAll && validQ[~busAddr[SECT_BIT]]) |=>
      validQ[~$past(busAddr[SECT_BIT])]);
endmodule

// File: rtl/flash_rd_page_cache.sv
module flash_rd_page_cache
  import frpc_pkg::*;
#(
  parameter logic [2:0] MAP_SLOT = 3'd0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busReq,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  output logic                 busRdy,
  output logic                 busErr,
  output logic [31:0]          busData,
  output logic                 arrReq,
  output logic [TAG_W-1:0]     arrPageAddr,
  input  logic [PAGE_BITS-1:0] arrPageData,
  input  logic                 progWrStb,
  input  logic                 eraseIlkStb,
  input  logic                 hvEnable,
  input  logic                 seqEnable,
  input  logic                 irqEnable
);
  strobe_t strb;
  logic    decErr, hit;

  frpc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busReq      (busReq),
    .decErr      (decErr),
    .hit         (hit),
    .progWrStb   (progWrStb),
    .eraseIlkStb (eraseIlkStb),
    .hvEnable    (hvEnable),
    .seqEnable   (seqEnable),
    .irqEnable   (irqEnable),
    .busRdy      (busRdy),
    .busErr      (busErr),
    .arrReq      (arrReq),
    .strb        (strb)
  );

  frpc_dpath #(.MAP_SLOT(MAP_SLOT)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busSize     (busSize),
    .strb        (strb),
    .arrPageData (arrPageData),
    .decErr      (decErr),
    .hit         (hit),
    .busData     (busData),
    .arrPageAddr (arrPageAddr)
  );
endmodule

// File: tb/flash_rd_page_cache_bench.sv
`timescale 1ns/1ps
module flash_rd_page_cache_bench;
  localparam logic [2:0] SLOT = 3'd2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busReq = 1'b0;
  logic [31:0]  busAddr = '0;
  logic [1:0]   busSize = '0;
  logic         busRdy, busErr, arrReq;
  logic [31:0]  busData;
  logic [16:0]  arrPageAddr;
  logic [255:0] arrPageData = '0;
  logic         progWrStb = 1'b0, eraseIlkStb = 1'b0;
  logic         hvEnable = 1'b0, seqEnable = 1'b0, irqEnable = 1'b0;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  flash_rd_page_cache #(.MAP_SLOT(SLOT)) u_flash_rd_page_cache (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busAddr(busAddr), .busSize(busSize),
    .busRdy(busRdy), .busErr(busErr), .busData(busData), .arrReq(arrReq),
    .arrPageAddr(arrPageAddr), .arrPageData(arrPageData), .progWrStb(progWrStb),
    .eraseIlkStb(eraseIlkStb), .hvEnable(hvEnable), .seqEnable(seqEnable),
    .irqEnable(irqEnable)
  );

  function automatic logic [31:0] pageWord(logic [16:0] tag, int w);
    return (32'(tag) * 32'h9E37_79B1) ^ (32'(w) * 32'h0101_0101) ^ 32'h5A00_00C3;
  endfunction

  // array model: answers one clock after a request
  always @(posedge clk) begin
    if (arrReq)
      for (int w = 0; w < 8; w++)
        arrPageData[(7 - w) * 32 +: 32] <= pageWord(arrPageAddr, w);
  end

  function automatic logic [31:0] expLanes(logic [31:0] w, logic [1:0] off, logic [1:0] sz);
    if (sz == 2'd0) begin
      case (off)
        2'd0: return {w[31:24], 24'h0};
        2'd1: return {8'h0, w[23:16], 16'h0};
        2'd2: return {16'h0, w[15:8], 8'h0};
        default: return {24'h0, w[7:0]};
      endcase
    end else if (sz == 2'd1) begin
      return off[1] ? {16'h0, w[15:0]} : {w[31:16], 16'h0};
    end
    return w;
  endfunction

  function automatic logic [31:0] mkAddr(int md, int blk, int row, int pg, int wd, int by);
    return {7'h0, SLOT, 4'(md), 3'(blk), 7'(row), 3'(pg), 3'(wd), 2'(by)};
  endfunction

  typedef struct packed {
    logic [31:0] data;
    logic        err;
    logic [3:0]  lat;
  } exp_t;
  exp_t  expQ[$];
  string reqQ[$];

  logic        mValid[2];
  logic [16:0] mTag[2];
  logic [16:0] expFetchTag;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  int lat = 0;
  always @(negedge clk) begin
    if (rstN && arrReq)
      check(arrPageAddr == expFetchTag, "R3", "fetch page address", 32'(arrPageAddr), 32'(expFetchTag));
    if (rstN && busReq) begin
      lat++;
      if (busRdy) begin
        exp_t e;
        string r;
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected completion", 32'(1), 32'(0));
        end else begin
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check(busData == e.data, r, "data", busData, e.data);
          check(busErr == e.err, r, "error flag", 32'(busErr), 32'(e.err));
          check(lat == int'(e.lat), r, "latency", 32'(lat), 32'(e.lat));
        end
        lat = 0;
      end
    end
  end

  task automatic clrModel();
    mValid[0] = 1'b0;
    mValid[1] = 1'b0;
  endtask

  task automatic doRead(logic [31:0] a, logic [1:0] sz, bit expErr, bit collide, string req);
    exp_t e;
    bit sec, isHit;
    logic [16:0] tag;
    sec = a[14];
    tag = a[21:5];
    if (expErr) begin
      e.data = '0; e.err = 1'b1; e.lat = 4'd1;
    end else begin
      isHit  = mValid[sec] && mTag[sec] == tag;
      e.data = expLanes(pageWord(tag, int'(a[4:2])), a[1:0], sz);
      e.err  = 1'b0;
      e.lat  = isHit ? 4'd1 : 4'd2;
      if (!isHit) begin
        mValid[sec] = !collide;
        mTag[sec]   = tag;
      end
    end
    expQ.push_back(e);
    reqQ.push_back(req);
    expFetchTag = tag;
    busAddr = a;
    busSize = sz;
    busReq  = 1'b1;
    forever begin
      @(negedge clk);
      if (busRdy) break;
      @(posedge clk); #1;
      if (collide) progWrStb = 1'b1;
    end
    @(posedge clk); #1;
    busReq    = 1'b0;
    progWrStb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1, a2, a3;
    clrModel();
    mTag[0] = '0; mTag[1] = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    @(negedge clk);
    // R1 reset state
    check(busRdy == 1'b0, "R1", "busRdy after reset", 32'(busRdy), 32'(0));
    check(busErr == 1'b0, "R1", "busErr after reset", 32'(busErr), 32'(0));
    check(arrReq == 1'b0, "R1", "arrReq after reset", 32'(arrReq), 32'(0));
    @(posedge clk); #1;

    a0 = mkAddr(0, 3, 7'h05, 2, 1, 0);   // section 0
    a1 = mkAddr(0, 3, 7'h45, 2, 1, 0);   // section 1
    a2 = mkAddr(1, 5, 7'h11, 6, 4, 0);   // section 0, other page
    a3 = mkAddr(1, 2, 7'h70, 1, 7, 0);   // section 1, other page

    doRead(a0, 2'd2, 0, 0, "R1");        // first read misses
    doRead(a0, 2'd2, 0, 0, "R4");
    for (int w = 0; w < 8; w++) doRead(a0 + 32'(w * 4), 2'd2, 0, 0, "R6");
    for (int b = 0; b < 4; b++) doRead(a0 + 32'(12 + b), 2'd0, 0, 0, "R6");
    doRead(a0 + 32'd20, 2'd1, 0, 0, "R6");
    doRead(a0 + 32'd22, 2'd1, 0, 0, "R6");
    doRead(a0 + 32'd7, 2'd3, 0, 0, "R6");
    doRead(a1, 2'd2, 0, 0, "R5");
    doRead(a0, 2'd2, 0, 0, "R5");
    doRead(a1 + 32'd4, 2'd0, 0, 0, "R5");
    doRead(a2, 2'd2, 0, 0, "R5");
    doRead(a1, 2'd2, 0, 0, "R5");
    doRead(a0, 2'd2, 0, 0, "R3");
    doRead(a3, 2'd1, 0, 0, "R3");

    // R2 rejected addresses, buffers kept
    doRead(a0 | 32'h0200_0000, 2'd2, 1, 0, "R2");
    doRead(a0 | 32'h8000_0000, 2'd2, 1, 0, "R2");
    doRead({a0[31:25], 3'd5, a0[21:0]}, 2'd2, 1, 0, "R2");
    doRead(mkAddr(2, 0, 1, 0, 0, 0), 2'd2, 1, 0, "R2");
    doRead(mkAddr(15, 0, 1, 0, 0, 0), 2'd2, 1, 0, "R2");
    doRead(mkAddr(1, 6, 1, 0, 0, 0), 2'd2, 1, 0, "R2");
    doRead(mkAddr(1, 7, 7'h41, 0, 0, 0), 2'd0, 1, 0, "R2");
    doRead(a0, 2'd2, 0, 0, "R2");
    doRead(a3, 2'd2, 0, 0, "R2");

    // R7 program / erase events
    idle(1); progWrStb = 1'b1; idle(1); progWrStb = 1'b0; clrModel();
    doRead(a0, 2'd2, 0, 0, "R7");
    doRead(a3, 2'd2, 0, 0, "R7");
    idle(1); eraseIlkStb = 1'b1; idle(1); eraseIlkStb = 1'b0; clrModel();
    doRead(a3, 2'd2, 0, 0, "R7");
    doRead(a0, 2'd2, 0, 0, "R7");

    // R8 high-voltage and sequence enable edges
    hvEnable = 1'b1; idle(1); clrModel();
    doRead(a0, 2'd2, 0, 0, "R8");
    hvEnable = 1'b0; idle(1);
    doRead(a0, 2'd2, 0, 0, "R8");
    seqEnable = 1'b1; idle(1);
    doRead(a0, 2'd2, 0, 0, "R8");
    seqEnable = 1'b0; idle(1); clrModel();
    doRead(a0, 2'd2, 0, 0, "R8");

    // R9 interrupt enable, both edges
    doRead(a1, 2'd2, 0, 0, "R9");
    irqEnable = 1'b1; idle(1); clrModel();
    doRead(a1, 2'd2, 0, 0, "R9");
    irqEnable = 1'b0; idle(1); clrModel();
    doRead(a1, 2'd2, 0, 0, "R9");
    doRead(a1, 2'd2, 0, 0, "R9");

    // R10 invalidation in the completion clock of a miss
    doRead(a2, 2'd2, 0, 1, "R10");
    doRead(a2, 2'd2, 0, 0, "R10");
    doRead(a2, 2'd2, 0, 0, "R10");

    idle(3);
    check(expQ.size() == 0, "R3", "pending expected items", 32'(expQ.size()), 32'(0));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule